// File: doc/BRIEF.md
# Coprocessor Debug Command Port

This block is the host's only way into a small coprocessor. The host sees five word registers: an address register, a data register, a combined control/status register, a watch counter and a profile counter. A host write of an operation code to the control register does one of two things. It either moves a word between the data register and one of three internal stores (instruction memory, data memory, execution-context registers), or it changes the execution state (start, halt, single-step, pipeline flush, profile clear). The coprocessor datapath is not modelled. The stores are plain memories, and a single step is a countdown that ends in a one-cycle step pulse and a watch-counter increment.

Reads are delayed. After a read operation, the data register goes on returning its old value for a fixed number of data-register reads, two by default. Only the read after those returns the fetched word. Software that polls the watch counter after a step can see when the step has retired.

Top module: `dbg_cmd_port`

## Requirements
- R1: After reset the control/status register (select 2) reads 0x6000_0000, which is halted bit 30 and flushed bit 29 set with running bit 31 clear. The address (select 0), data (select 1), watch (select 3) and profile (select 4) registers read zero.
- R2: Operation codes 0x11, 0x13 and 0x15 write the data-register word into instruction memory, data memory or context registers respectively. The entry is chosen by the low bits of the address register, and the status bits do not change.
- R3: Operation codes 0x10, 0x12 and 0x14 fetch the addressed instruction word, data word or context register. The next STALE_READS (2) data-register reads return the data register's previous value. The read after those returns the fetched word, and later reads keep returning it.
- R4: A host write to the data register is returned by the very next data-register read.
- R5: Operation 0x02 (start) sets running and clears halted and flushed. Operation 0x03 (halt) clears running and sets halted. Running and halted are never equal.
- R6: Operation 0x04 (flush) sets the flushed bit and leaves running and halted unchanged.
- R7: Operation 0x01 (step) issued while halted raises the step pulse for exactly one cycle and clears flushed. STEP_CYCLES (3) clock edges after the command, the watch counter has grown by exactly one. At no other time does the watch counter change, except through a host write.
- R8: A step issued while running, or while an earlier step is still counting down, is ignored.
- R9: While running, the profile counter increments on every clock. While halted it holds its value. Operation 0x0C clears it.
- R10: Any operation code not listed above changes neither the status bits nor any store.
- R11: A host write to the watch register (select 3) loads it directly.
- R12: The three stores are separate: the same address in each keeps its own word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (a data-register read advances the read pipeline) |
| host_addr | input | 3 | Register select: 0 address, 1 data, 2 control/status, 3 watch, 4 profile |
| host_wdata | input | 32 | Host write data; bits 7:0 are the operation code for select 2 |
| host_rdata | output | 32 | Selected register value, valid in the cycle of the read |
| core_run | output | 1 | Coprocessor running |
| core_step | output | 1 | One-cycle single-step pulse |

## Verification
The hardest states to reach from the ports are the two short windows in which an operation must be ignored or must not be visible yet. One is the stale-read window after a fetch. The other is the countdown of a pending step. The bench reaches the read window by loading a known marker into the data register just before each fetch, so that the stale reads and the fresh read can be told apart. It reaches the step window by issuing a second step and a watch-counter peek a fixed number of cycles after the first step, while the countdown is still running. The step pulse is counted by a monitor across the whole run.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

   typedef enum logic [7:0] {
      OP_STEP     = 8'h01,
      OP_START    = 8'h02,
      OP_HALT     = 8'h03,
      OP_FLUSH    = 8'h04,
      OP_PROF_CLR = 8'h0C,
      OP_IMEM_RD  = 8'h10,
      OP_IMEM_WR  = 8'h11,
      OP_DMEM_RD  = 8'h12,
      OP_DMEM_WR  = 8'h13,
      OP_CTX_RD   = 8'h14,
      OP_CTX_WR   = 8'h15
   } dcp_op_e;

   localparam int unsigned HOST_W = 32;
   localparam int unsigned SEL_W  = 3;

   localparam logic [SEL_W-1:0] SEL_ADDR  = 3'd0;
   localparam logic [SEL_W-1:0] SEL_DATA  = 3'd1;
   localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd2;
   localparam logic [SEL_W-1:0] SEL_WATCH = 3'd3;
   localparam logic [SEL_W-1:0] SEL_PROF  = 3'd4;

   function automatic logic op_is_fetch(input logic [7:0] code);
      return (code == OP_IMEM_RD) || (code == OP_DMEM_RD) || (code == OP_CTX_RD);
   endfunction

endpackage

// File: rtl/dcp_store.sv
module dcp_store #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 256
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [WIDTH-1:0]         wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [WIDTH-1:0]         rdata
);
   localparam int unsigned AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("dcp_store: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/dcp_read_pipe.sv
module dcp_read_pipe #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned STALE = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic             fetch,
   input  logic [WIDTH-1:0] fetch_val,
   input  logic             pop,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] data_q;

   generate
      if (STALE == 0) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     data_q <= '0;
            else if (load)  data_q <= load_val;
            else if (fetch) data_q <= fetch_val;
         end
         logic unused_pop;
         assign unused_pop = pop;
      end else begin : g_staged
         logic [WIDTH-1:0] stg_q [STALE];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q <= '0;
               for (int k = 0; k < STALE; k++) stg_q[k] <= '0;
            end else if (load) begin
               data_q <= load_val;
               for (int k = 0; k < STALE; k++) stg_q[k] <= load_val;
            end else if (fetch) begin
               stg_q[0] <= fetch_val;
               for (int k = 1; k < STALE; k++) stg_q[k] <= data_q;
            end else if (pop) begin
               data_q <= stg_q[STALE-1];
               for (int k = 1; k < STALE; k++) stg_q[k] <= stg_q[k-1];
            end
         end
      end
   endgenerate

   assign dout = data_q;
endmodule

// File: rtl/dcp_exec_ctl.sv
module dcp_exec_ctl
   import dcp_pkg::*;
#(
   parameter int unsigned WATCH_W     = 32,
   parameter int unsigned PROF_W      = 32,
   parameter int unsigned STEP_CYCLES = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_valid,
   input  logic [7:0]         op,
   input  logic               watch_we,
   input  logic [WATCH_W-1:0] watch_wval,
   output logic               run,
   output logic               halted,
   output logic               flushed,
   output logic [WATCH_W-1:0] watch,
   output logic [PROF_W-1:0]  prof,
   output logic               step_pulse
);
   localparam int unsigned CW = $clog2(STEP_CYCLES + 1);

   generate
      if (STEP_CYCLES < 1) begin : g_bad_step
         $error("dcp_exec_ctl: STEP_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          step_ok;

   assign step_pulse = (cnt_q == CW'(1));
   assign step_ok    = !run && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         halted  <= 1'b1;
         flushed <= 1'b1;
         cnt_q   <= '0;
         watch   <= '0;
         prof    <= '0;
      end else begin
         if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);

         if (watch_we)        watch <= watch_wval;
         else if (step_pulse) watch <= watch + WATCH_W'(1);

         if (op_valid && op == OP_PROF_CLR) prof <= '0;
         else if (run)                      prof <= prof + PROF_W'(1);

         if (op_valid) begin
            case (op)
               OP_START: begin
                  run     <= 1'b1;
                  halted  <= 1'b0;
                  flushed <= 1'b0;
               end
               OP_HALT: begin
                  run    <= 1'b0;
                  halted <= 1'b1;
               end
               OP_FLUSH: flushed <= 1'b1;
               OP_STEP: begin
                  if (step_ok) begin
                     cnt_q   <= CW'(STEP_CYCLES);
                     flushed <= 1'b0;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/dbg_cmd_port.sv
module dbg_cmd_port
   import dcp_pkg::*;
#(
   parameter int unsigned IMEM_DEPTH  = 256,
   parameter int unsigned DMEM_DEPTH  = 256,
   parameter int unsigned CTX_DEPTH   = 32,
   parameter int unsigned STALE_READS = 2,
   parameter int unsigned STEP_CYCLES = 3,
   parameter int unsigned WATCH_W     = 32,
   parameter int unsigned PROF_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic              host_rd,
   input  logic [SEL_W-1:0]  host_addr,
   input  logic [HOST_W-1:0] host_wdata,
   output logic [HOST_W-1:0] host_rdata,
   output logic              core_run,
   output logic              core_step
);
   localparam int unsigned IAW = $clog2(IMEM_DEPTH);
   localparam int unsigned DAW = $clog2(DMEM_DEPTH);
   localparam int unsigned CAW = $clog2(CTX_DEPTH);

   generate
      if (STALE_READS > 4) begin : g_bad_stale
         $error("dbg_cmd_port: STALE_READS above 4 is not supported");
      end
      if (WATCH_W > HOST_W || PROF_W > HOST_W || WATCH_W < 1 || PROF_W < 1) begin : g_bad_cnt
         $error("dbg_cmd_port: counter widths must be 1..HOST_W");
      end
      if (IAW > HOST_W || DAW > HOST_W || CAW > HOST_W) begin : g_bad_aw
         $error("dbg_cmd_port: store depth exceeds address register");
      end
   endgenerate

   logic [HOST_W-1:0]  addr_q;
   logic [HOST_W-1:0]  data_w;
   logic               op_valid;
   logic [7:0]         op_code;
   logic               run_w, halted_w, flushed_w, step_w;
   logic [WATCH_W-1:0] watch_w;
   logic [PROF_W-1:0]  prof_w;
   logic [HOST_W-1:0]  watch_x, prof_x;
   logic [HOST_W-1:0]  imem_rd, dmem_rd, ctx_rd;
   logic [HOST_W-1:0]  fetch_val;

   assign op_valid = host_we && (host_addr == SEL_CTRL);
   assign op_code  = host_wdata[7:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               addr_q <= '0;
      else if (host_we && host_addr == SEL_ADDR) addr_q <= host_wdata;
   end

   // R2, R12: three separate stores on the shared address/data registers
   dcp_store #(.WIDTH(HOST_W), .DEPTH(IMEM_DEPTH)) u_imem (
      .clk   (clk),
      .we    (op_valid && op_code == OP_IMEM_WR),
      .waddr (addr_q[IAW-1:0]),
      .wdata (data_w),
      .raddr (addr_q[IAW-1:0]),
      .rdata (imem_rd)
   );

   dcp_store #(.WIDTH(HOST_W), .DEPTH(DMEM_DEPTH)) u_dmem (
      .clk   (clk),
      .we    (op_valid && op_code == OP_DMEM_WR),
      .waddr (addr_q[DAW-1:0]),
      .wdata (data_w),
      .raddr (addr_q[DAW-1:0]),
      .rdata (dmem_rd)
   );

   dcp_store #(.WIDTH(HOST_W), .DEPTH(CTX_DEPTH)) u_ctx (
      .clk   (clk),
      .we    (op_valid && op_code == OP_CTX_WR),
      .waddr (addr_q[CAW-1:0]),
      .wdata (data_w),
      .raddr (addr_q[CAW-1:0]),
      .rdata (ctx_rd)
   );

   always_comb begin
      case (op_code)
         OP_IMEM_RD: fetch_val = imem_rd;
         OP_DMEM_RD: fetch_val = dmem_rd;
         default:    fetch_val = ctx_rd;
      endcase
   end

   // R3, R4: delayed read-back through the data register
   dcp_read_pipe #(.WIDTH(HOST_W), .STALE(STALE_READS)) u_rpipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (host_we && host_addr == SEL_DATA),
      .load_val  (host_wdata),
      .fetch     (op_valid && op_is_fetch(op_code)),
      .fetch_val (fetch_val),
      .pop       (host_rd && host_addr == SEL_DATA),
      .dout      (data_w)
   );

   // R5-R11: execution state, step countdown and counters
   dcp_exec_ctl #(
      .WATCH_W     (WATCH_W),
      .PROF_W      (PROF_W),
      .STEP_CYCLES (STEP_CYCLES)
   ) u_exec (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_valid   (op_valid),
      .op         (op_code),
      .watch_we   (host_we && host_addr == SEL_WATCH),
      .watch_wval (host_wdata[WATCH_W-1:0]),
      .run        (run_w),
      .halted     (halted_w),
      .flushed    (flushed_w),
      .watch      (watch_w),
      .prof       (prof_w),
      .step_pulse (step_w)
   );

   assign watch_x = HOST_W'(watch_w);
   assign prof_x  = HOST_W'(prof_w);

   always_comb begin
      case (host_addr)
         SEL_ADDR:  host_rdata = addr_q;
         SEL_DATA:  host_rdata = data_w;
         SEL_CTRL:  host_rdata = {run_w, halted_w, flushed_w, {(HOST_W-3){1'b0}}};
         SEL_WATCH: host_rdata = watch_x;
         SEL_PROF:  host_rdata = prof_x;
         default:   host_rdata = '0;
      endcase
   end

   assign core_run  = run_w;
   assign core_step = step_w;
endmodule

// File: rtl/dcp_checks.sv
module dcp_checks
   import dcp_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        host_we,
   input logic [2:0]  host_addr,
   input logic [31:0] host_wdata,
   input logic        run,
   input logic        halted,
   input logic        flushed,
   input logic [31:0] watch,
   input logic [31:0] prof,
   input logic        step_pulse
);
   logic       op_v, watch_wr, known;
   logic [7:0] op;

   assign op       = host_wdata[7:0];
   assign op_v     = host_we && host_addr == 3'd2;
   assign watch_wr = host_we && host_addr == 3'd3;
   assign known    = (op == 8'h01) || (op == 8'h02) || (op == 8'h03) || (op == 8'h04) ||
                     (op == 8'h0C) || (op >= 8'h10 && op <= 8'h15);

   assert_run_xor_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({run, halted}));

   assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      op_v && op == 8'h02 |=> run && !halted && !flushed);

   assert_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      op_v && op == 8'h03 |=> !run && halted);

   assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
      op_v && op == 8'h04 |=> flushed && $stable(run));

   assert_watch_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !watch_wr && !step_pulse |=> $stable(watch));

   assert_watch_plus1_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !watch_wr && step_pulse |=> watch == $past(watch) + 32'd1);

   assert_prof_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !(op_v && op == 8'h0C) |=> $stable(prof));

   assert_prof_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      op_v && op == 8'h0C |=> prof == 32'd0);

   assert_unknown_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
      op_v && !known |=> $stable({run, halted, flushed}));

   assert_watch_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      watch_wr |=> watch == $past(host_wdata));
endmodule

bind dbg_cmd_port dcp_checks u_dcp_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_we    (host_we),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .run        (run_w),
   .halted     (halted_w),
   .flushed    (flushed_w),
   .watch      (watch_x),
   .prof       (prof_x),
   .step_pulse (step_w)
);

// File: tb/dbg_cmd_port_bench.sv
module dbg_cmd_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic        host_rd = 1'b0;
   logic [2:0]  host_addr = 3'd0;
   logic [31:0] host_wdata = 32'd0;
   logic [31:0] host_rdata;
   logic        core_run, core_step;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   bit peek_on = 1'b0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] v;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   dbg_cmd_port u_dbg_cmd_port (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .core_run(core_run), .core_step(core_step)
   );

   localparam logic [2:0] A_ADDR = 3'd0, A_DATA = 3'd1, A_CTRL = 3'd2,
                          A_WATCH = 3'd3, A_PROF = 3'd4;

   // monitor: pops expected items and compares, counts step pulses
   always begin
      @(negedge clk);
      #3;
      if (core_step) pulses++;
      if (host_rd && !peek_on) begin
         checks++;
         if (sb_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: unexpected read, actual %h expected none", host_rdata);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (host_rdata !== e.v) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", e.tag, host_rdata, e.v);
            end
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp_v, input string tag);
      exp_t e;
      e.v = exp_v; e.tag = tag;
      sb_q.push_back(e);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a; peek_on = 1'b1;
      #3 v = host_rdata;
      @(negedge clk);
      host_rd = 1'b0; peek_on = 1'b0;
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] exp_v, input string tag);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v, w0, p;
      int tries;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_CTRL, 32'h6000_0000, "R1 status");
      rd(A_WATCH, 32'd0, "R1 watch");
      rd(A_PROF, 32'd0, "R1 profile");
      rd(A_DATA, 32'd0, "R1 data");
      rd(A_ADDR, 32'd0, "R1 addr");

      // R2, R12 writes to all three stores at address 5
      wr(A_ADDR, 32'd5);
      wr(A_DATA, 32'h1111_0005); wr(A_CTRL, 32'h11);
      wr(A_DATA, 32'h2222_0005); wr(A_CTRL, 32'h13);
      wr(A_DATA, 32'h3333_0005); wr(A_CTRL, 32'h15);
      rd(A_CTRL, 32'h6000_0000, "R2 status unchanged");

      // R3 stale reads then fetched word
      wr(A_DATA, 32'hDEAD_0000); wr(A_CTRL, 32'h10);
      rd(A_DATA, 32'hDEAD_0000, "R3 stale1 imem");
      rd(A_DATA, 32'hDEAD_0000, "R3 stale2 imem");
      rd(A_DATA, 32'h1111_0005, "R3 fresh imem R12");
      rd(A_DATA, 32'h1111_0005, "R3 hold imem");
      wr(A_CTRL, 32'h12);
      rd(A_DATA, 32'h1111_0005, "R3 stale1 dmem");
      rd(A_DATA, 32'h1111_0005, "R3 stale2 dmem");
      rd(A_DATA, 32'h2222_0005, "R3 fresh dmem R12");
      wr(A_CTRL, 32'h14);
      rd(A_DATA, 32'h2222_0005, "R3 stale1 ctx");
      rd(A_DATA, 32'h2222_0005, "R3 stale2 ctx");
      rd(A_DATA, 32'h3333_0005, "R3 fresh ctx R12");

      // R4 direct data-register write
      wr(A_DATA, 32'h0000_CAFE);
      rd(A_DATA, 32'h0000_CAFE, "R4 immediate");
      rd(A_DATA, 32'h0000_CAFE, "R4 repeat");

      // R10 unknown codes ignored
      wr(A_DATA, 32'h0000_9999);
      wr(A_CTRL, 32'h16); wr(A_CTRL, 32'h07); wr(A_CTRL, 32'hFF);
      rd(A_CTRL, 32'h6000_0000, "R10 status");
      wr(A_CTRL, 32'h10);
      rd(A_DATA, 32'h0000_9999, "R10 stale1");
      rd(A_DATA, 32'h0000_9999, "R10 stale2");
      rd(A_DATA, 32'h1111_0005, "R10 imem untouched");

      // R7 single step while halted
      peek(A_WATCH, w0);
      pulses = 0;
      wr(A_CTRL, 32'h01);
      peek(A_WATCH, v);
      chk(v, w0, "R7 watch not yet advanced");
      tries = 0;
      while (v == w0 && tries < 1000) begin peek(A_WATCH, v); tries++; end
      rd(A_WATCH, w0 + 32'd1, "R7 watch plus one");
      chk(32'(pulses), 32'd1, "R7 one step pulse");
      rd(A_CTRL, 32'h4000_0000, "R7 flushed cleared");

      // R8 second step during countdown ignored
      pulses = 0;
      wr(A_CTRL, 32'h01);
      wr(A_CTRL, 32'h01);
      repeat (10) @(negedge clk);
      rd(A_WATCH, w0 + 32'd2, "R8 overlapping step ignored");
      chk(32'(pulses), 32'd1, "R8 single pulse");

      // R6 flush while halted
      wr(A_CTRL, 32'h04);
      rd(A_CTRL, 32'h6000_0000, "R6 flush halted");

      // R5 start
      wr(A_CTRL, 32'h02);
      rd(A_CTRL, 32'h8000_0000, "R5 running");
      chk({31'd0, core_run}, 32'd1, "R5 core_run");

      // R8 step while running ignored
      pulses = 0;
      wr(A_CTRL, 32'h01);
      repeat (10) @(negedge clk);
      rd(A_WATCH, w0 + 32'd2, "R8 step while running");
      chk(32'(pulses), 32'd0, "R8 no pulse while running");

      // R9 profile counts while running
      peek(A_PROF, p);
      rd(A_PROF, p + 32'd2, "R9 counting");

      // R6 flush while running
      wr(A_CTRL, 32'h04);
      rd(A_CTRL, 32'hA000_0000, "R6 flush running");

      // R5 halt
      wr(A_CTRL, 32'h03);
      rd(A_CTRL, 32'h6000_0000, "R5 halted");

      // R9 hold and clear
      peek(A_PROF, p);
      repeat (5) @(negedge clk);
      rd(A_PROF, p, "R9 hold halted");
      wr(A_CTRL, 32'h0C);
      rd(A_PROF, 32'd0, "R9 cleared");

      // R11 watch load, then step from the loaded value
      wr(A_WATCH, 32'h0000_0100);
      rd(A_WATCH, 32'h0000_0100, "R11 watch loaded");
      wr(A_CTRL, 32'h01);
      repeat (6) @(negedge clk);
      rd(A_WATCH, 32'h0000_0101, "R7 step from loaded value");

      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
      end
      finish_run();
   end
endmodule